// File: doc/BRIEF.md
# Event Statistics Counter Bank

This block keeps running tallies of two kinds of events: the moments a link is turned on, and the assertions of each of eight interrupt request lines. Each tally counts rising edges, so a line that stays high for many cycles counts once. Interrupt lines are tapped before any masking, so every request is counted whatever software has chosen to enable.

A host reads the tallies over a small word-addressed bus with separate read and write strobes. The interrupt tallies are packed two to a 32-bit word. A single write to a control word with bit 0 set zeroes every tally at once. Tallies stop at their maximum value instead of rolling over, so a reading of all ones means "at least this many".

Top module: `evstat_bank`

## Requirements
- R1: After synchronous reset every tally is zero, and a read of any mapped word returns 0.
- R2: The link tally goes up by one for each low-to-high transition of `link_en`. A line held high for many cycles adds exactly one.
- R3: Each of the eight interrupt lines has its own 16-bit tally. Each tally counts rising edges of its own line only, and lines that rise in the same cycle are all counted.
- R4: Interrupt tallies sit two per word at word addresses 0x0B4 + k for k = 0..3. Line 2k is in bits [15:0] and line 2k+1 is in bits [31:16].
- R5: The link tally reads at word address 0x0B1 in bits [15:0], with bits [31:16] at zero.
- R6: A write to word address 0x0B0 with bit 0 of the write data at 1 sets all nine tallies to zero. A write there with bit 0 at 0 changes nothing.
- R7: If a clear write and a counted edge fall in the same cycle, the tally reads zero afterwards.
- R8: A tally that has reached 0xFFFF stays at 0xFFFF on further edges.
- R9: A read of the control word 0x0B0, or of any address outside 0x0B1 and 0x0B4..0x0B7, returns 0.
- R10: Writes to the tally words 0x0B1 and 0x0B4..0x0B7 have no effect on any tally.
- R11: Read data is registered. It shows the addressed word in the cycle after `bus_rd` is sampled high, and it holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_en | input | 1 | Link enable level; each rising edge is counted |
| irq_lines | input | 8 | Unmasked interrupt request levels, one per line |
| bus_addr | input | 10 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only bit 0 of the control word is used |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench holds `link_en` high for many cycles to catch a design that counts levels instead of edges; such a design would report the hold length instead of one. It raises a clear write and several edges in the same cycle; a design that let the edge win would read 1 after the clear. It drives over 65,000 edges into one interrupt line to show the tally pins at 0xFFFF instead of wrapping to a small value, and the partner half of that word shows that packing keeps neighbours apart. It also writes all ones to tally words, which would wrongly clear or load a design that decoded writes too loosely, and it reads unmapped addresses after the tallies are non-zero so that stray decode would show up as non-zero data.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
  // Bus word width and the half-word each packed tally occupies.
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  // Word addresses of the register map.
  localparam int unsigned CTRL_WORD     = 'h0B0;
  localparam int unsigned LINK_WORD     = 'h0B1;
  localparam int unsigned IRQ_BASE_WORD = 'h0B4;

  // Bit of the control word that requests a clear.
  localparam int unsigned CLR_BIT = 0;
endpackage

// File: rtl/evstat_edge.sv
module evstat_edge #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R2: a line held high yields no second event in the following cycle.
  assert_one_shot_R2: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/evstat_counter.sv
module evstat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ev,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (ev && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R6 / R7: a clear leaves zero behind even if an event came with it.
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R8: a full tally does not wrap.
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  // R2 / R3: without an event or a clear the tally does not move.
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ev) |=> $stable(count));

  // R3: a tally rises by at most one per cycle.
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && ev && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/evstat_regbus.sv
module evstat_regbus
  import evstat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_IRQ = 8,   // must be even
  parameter int unsigned CNT_W   = 16   // must not exceed HALF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [WORD_W-1:0]        bus_wdata,
  input  logic                     bus_rd,
  input  logic [CNT_W-1:0]         link_cnt,
  input  logic [NUM_IRQ*CNT_W-1:0] irq_cnt,
  output logic                     clr_pulse,
  output logic [WORD_W-1:0]        bus_rdata
);
  localparam int unsigned NUM_PAIRS = NUM_IRQ / 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_WORD);
  localparam logic [ADDR_W-1:0] A_LINK = ADDR_W'(LINK_WORD);

  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;
  logic              hit_any;
  wire               unused_wdata = ^bus_wdata[WORD_W-1:CLR_BIT+1];

  assign clr_pulse = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CLR_BIT];

  always_comb begin
    rd_word = '0;
    hit_any = 1'b0;
    if (bus_addr == A_LINK) begin
      rd_word[CNT_W-1:0] = link_cnt;
      hit_any            = 1'b1;
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (bus_addr == ADDR_W'(IRQ_BASE_WORD + p)) begin
        rd_word[CNT_W-1:0]       = irq_cnt[(2*p)*CNT_W +: CNT_W];
        rd_word[HALF_W +: CNT_W] = irq_cnt[(2*p+1)*CNT_W +: CNT_W];
        hit_any                  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;

  // R9: unmapped or control reads return zero.
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit_any) |=> (bus_rdata == '0));

  // R11: read data holds while no read is requested.
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R5: the upper half of the link word is always zero.
  assert_link_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_LINK) |=> (bus_rdata[WORD_W-1:HALF_W] == '0));
endmodule

// File: rtl/evstat_bank.sv
module evstat_bank
  import evstat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_en,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [WORD_W-1:0]  bus_rdata
);
  localparam int unsigned NUM_EV = NUM_IRQ + 1;  // bit 0 is the link

  logic [NUM_EV-1:0]        ev_rise;
  logic [CNT_W-1:0]         link_cnt;
  logic [NUM_IRQ*CNT_W-1:0] irq_cnt;
  logic                     clr_pulse;

  evstat_edge #(.W(NUM_EV)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({irq_lines, link_en}),
    .rise (ev_rise)
  );

  evstat_counter #(.CNT_W(CNT_W)) link_cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_pulse),
    .ev    (ev_rise[0]),
    .count (link_cnt)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    evstat_counter #(.CNT_W(CNT_W)) irq_cnt_i (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_pulse),
      .ev    (ev_rise[g+1]),
      .count (irq_cnt[g*CNT_W +: CNT_W])
    );
  end

  evstat_regbus #(
    .ADDR_W  (ADDR_W),
    .NUM_IRQ (NUM_IRQ),
    .CNT_W   (CNT_W)
  ) regbus_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .link_cnt  (link_cnt),
    .irq_cnt   (irq_cnt),
    .clr_pulse (clr_pulse),
    .bus_rdata (bus_rdata)
  );

  // R6: a clear write empties every tally by the next cycle.
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> (link_cnt == '0 && irq_cnt == '0));

  // R10: a write to any address but the control word leaves tallies untouched
  // unless an edge arrives.
  assert_wr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != ADDR_W'(CTRL_WORD) && ev_rise == '0)
      |=> ($stable(link_cnt) && $stable(irq_cnt)));
endmodule

// File: tb/evstat_bank_tb.sv
`timescale 1ns/1ps
module evstat_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        link_en;
  logic [7:0]  irq_lines;
  logic [9:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  evstat_bank dut_i (
    .clk       (clk),
    .rst       (rst),
    .link_en   (link_en),
    .irq_lines (irq_lines),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_word(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_link(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); link_en = 1'b1;
      @(negedge clk); link_en = 1'b0;
    end
  endtask

  task automatic pulse_irq(input logic [7:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); irq_lines = mask;
      @(negedge clk); irq_lines = '0;
    end
  endtask

  task automatic do_clear();
    wr_word(10'h0B0, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_word(10'h0B1, d); check("R1 link after reset", d, 0);
    for (int k = 0; k < 4; k++) begin
      rd_word(10'h0B4 + 10'(k), d); check("R1 irq word after reset", d, 0);
    end
  endtask

  task automatic t_link_edges();
    logic [31:0] d;
    pulse_link(3);
    @(negedge clk); link_en = 1'b1;
    repeat (10) @(negedge clk);
    link_en = 1'b0;
    rd_word(10'h0B1, d);
    check("R2 link edges with long hold", d, 4);
    check("R5 link upper half zero", {16'h0, d[31:16]}, 0);
  endtask

  task automatic t_irq_pack();
    logic [31:0] d;
    for (int k = 0; k < 8; k++) pulse_irq(8'(1 << k), k + 1);
    pulse_irq(8'hFF, 1);  // all lines in the same cycle
    for (int p = 0; p < 4; p++) begin
      rd_word(10'h0B4 + 10'(p), d);
      check("R4 irq pair packing", d, {16'(2*p + 3), 16'(2*p + 2)});
    end
    @(negedge clk); irq_lines = 8'h04;
    repeat (5) @(negedge clk);
    irq_lines = '0;
    rd_word(10'h0B5, d);
    check("R3 held line counts once", d, {16'd5, 16'd5});
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd_word(10'h0B0, d); check("R9 control reads zero", d, 0);
    rd_word(10'h0B2, d); check("R9 gap 0x0B2 reads zero", d, 0);
    rd_word(10'h0B3, d); check("R9 gap 0x0B3 reads zero", d, 0);
    rd_word(10'h0B8, d); check("R9 past end reads zero", d, 0);
    rd_word(10'h000, d); check("R9 address zero reads zero", d, 0);
  endtask

  task automatic t_write_ignored();
    logic [31:0] d;
    wr_word(10'h0B1, 32'hFFFF_FFFF);
    wr_word(10'h0B4, 32'hFFFF_FFFF);
    rd_word(10'h0B1, d); check("R10 link word write ignored", d, 4);
    rd_word(10'h0B4, d); check("R10 irq word write ignored", d, {16'd3, 16'd2});
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd_word(10'h0B1, d);
    pulse_link(2);
    @(negedge clk);
    check("R11 rdata holds without read", bus_rdata, d);
    rd_word(10'h0B1, d); check("R11 fresh read updates", d, 6);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr_word(10'h0B0, 32'hFFFF_FFFE);  // bit 0 low: no clear
    rd_word(10'h0B1, d); check("R6 bit0 low does not clear", d, 6);
    do_clear();
    rd_word(10'h0B1, d); check("R6 link cleared", d, 0);
    for (int p = 0; p < 4; p++) begin
      rd_word(10'h0B4 + 10'(p), d); check("R6 irq word cleared", d, 0);
    end
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    pulse_link(2);
    @(negedge clk);
    bus_addr = 10'h0B0; bus_wdata = 32'h1; bus_wr = 1'b1;
    link_en = 1'b1; irq_lines = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    link_en = 1'b0; irq_lines = '0;
    rd_word(10'h0B1, d); check("R7 clear beats link edge", d, 0);
    rd_word(10'h0B4, d); check("R7 clear beats irq edge", d, 0);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    do_clear();
    pulse_irq(8'h01, 1);
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk); irq_lines = 8'h80;
      @(negedge clk); irq_lines = 8'h00;
    end
    rd_word(10'h0B7, d);
    check("R8 irq7 saturates at 0xFFFF", {16'h0, d[31:16]}, 32'h0000_FFFF);
    check("R4 irq6 untouched beside full irq7", {16'h0, d[15:0]}, 0);
    rd_word(10'h0B4, d);
    check("R3 irq0 independent of irq7", d, 32'h0000_0001);
  endtask

  initial begin
    rst = 1'b1; link_en = 1'b0; irq_lines = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 rdata zero in reset", bus_rdata, 0);
    rst = 1'b0;
    t_reset();
    t_link_edges();
    t_irq_pack();
    t_unmapped();
    t_write_ignored();
    t_read_hold();
    t_clear();
    t_clear_race();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule